// File: doc/BRIEF.md
# Multi-Mode Chien Search and Forney Error Corrector

This block is the final stage of a small Reed-Solomon decoder that corrects up to three symbol errors. A key-equation solver upstream supplies the error count and the locator and evaluator coefficients. The block then walks through every position of the codeword in order. At each position it tests the error locator for a root. Where it finds one, it forms the error magnitude as the evaluator divided by the formal derivative of the locator, and XORs that magnitude onto the received symbol. Received symbols come from an external buffer, at most one per cycle.

A single cubic datapath serves every error count. In the lower modes the locator coefficients that the mode does not use are replaced by fixed 0 or 1 values, and so are the evaluator coefficients. The derivative term then reduces to the right divisor without any extra circuit. Each power term of the locator and evaluator lives in its own register and is stepped once per accepted symbol by a fixed power of alpha. The only general multiplier is the one that applies the inverse in the Forney division.

The field is GF(2^m) with m = 4 by default, built from the primitive polynomial x^4 + x + 1 with alpha = 2. A block holds N = 2^m - 1 symbols. Symbol number l after a start is the coefficient of x^l and is tested against x = alpha^l.

Top module: `rs_chien_forney`

## Requirements
- R1: While reset is held, and after it is released, sym_vld_o, corr_o, done_o and fail_o are low until a block produces output.
- R2: After a start_i cycle, the block accepts exactly N = 2^m - 1 symbols, taking each cycle in which rx_vld_i is high. The l-th accepted symbol (l counted from 0) is position l. Its result appears on sym_o with sym_vld_o high in the cycle after it is accepted, and results come out in input order.
- R3: With err_cnt_i = 3, the locator is sigma0 + sigma1 x + sigma2 x^2 + x^3. At each root X = alpha^l the output is rx ^ (omega0 + omega1 X + omega2 X^2) / (sigma1 + X^2).
- R4: With err_cnt_i = 2, the locator is sigma0 + sigma1 x + x^2 and the magnitude is (omega0 + omega1 X) / sigma1. The sigma2_i and omega2_i inputs have no effect.
- R5: With err_cnt_i = 1, the locator is sigma0 + x and the magnitude is omega0. The sigma1_i, sigma2_i, omega1_i and omega2_i inputs have no effect.
- R6: With err_cnt_i = 0, every symbol passes through unchanged, corr_o stays low and fail_o stays low. No coefficient input has an effect.
- R7: corr_o is high with an output symbol exactly when that position is a root of the selected locator and the mode is not 0. A position that is not a root leaves the symbol unchanged.
- R8: done_o is a single-cycle pulse that comes with the output of the last position. fail_o is high in that same cycle exactly when the number of roots found differs from the error count, and is low at all other times.
- R9: rx_vld_i has no effect when no block is in progress: no output appears.
- R10: Cycles with rx_vld_i low inside a block hold the search position. Neither the position nor the output sequence advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch the coefficients and begin a new block |
| err_cnt_i | input | 2 | Error count from the solver, 0 to 3 |
| sigma0_i | input | m | Locator coefficient of x^0 |
| sigma1_i | input | m | Locator coefficient of x^1 |
| sigma2_i | input | m | Locator coefficient of x^2 |
| omega0_i | input | m | Evaluator coefficient of x^0 |
| omega1_i | input | m | Evaluator coefficient of x^1 |
| omega2_i | input | m | Evaluator coefficient of x^2 |
| rx_vld_i | input | 1 | Received symbol valid |
| rx_sym_i | input | m | Received symbol |
| sym_vld_o | output | 1 | Output symbol valid |
| sym_o | output | m | Corrected symbol |
| corr_o | output | 1 | This output symbol was altered |
| done_o | output | 1 | Last output of the block |
| fail_o | output | 1 | Root count differs from the error count (with done_o) |

## Verification
Every accepted symbol produces its result, together with corr_o, exactly one cycle later. done_o and fail_o belong to the result of the last symbol. The bench records each accepted symbol with the cycle number in which it was driven. On every cycle it expects output if and only if the oldest record is from the previous cycle, so a result that comes early, late, twice or never fails a check. Expected symbols are the original encoded codeword, computed from an independent polynomial model, and the blocks include stalls, ignored coefficient inputs and a locator that has no roots.

// File: rtl/rs_chien_pkg.sv
`timescale 1ns/1ps
package rs_chien_pkg;
  parameter int unsigned GF_M = 4;
  parameter logic [GF_M:0] GF_POLY = 5'b10011;
  localparam int unsigned GF_N = (1 << GF_M) - 1;

  typedef logic [GF_M-1:0] sym_t;
  typedef enum logic [1:0] {T_NONE, T_ONE, T_TWO, T_THREE} tmode_e;

  function automatic sym_t gf_xtime(sym_t a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_POLY[GF_M-1:0] : '0);
  endfunction

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t p = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      p = gf_xtime(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic sym_t gf_alpha_pow(int unsigned k);
    sym_t p = sym_t'(1);
    for (int unsigned i = 0; i < k; i++) p = gf_xtime(p);
    return p;
  endfunction

  // a^(2^m-2) by squarings: a^2 * a^4 * ... * a^(2^(m-1))
  function automatic sym_t gf_inv(sym_t a);
    sym_t r = sym_t'(1);
    sym_t s = a;
    for (int unsigned i = 1; i < GF_M; i++) begin
      s = gf_mul(s, s);
      r = gf_mul(r, s);
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_step_term.sv
`timescale 1ns/1ps
module rs_step_term
  import rs_chien_pkg::*;
#(
  parameter int unsigned STEP = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  sym_t init_i,
  input  logic adv_i,
  output sym_t val_o
);
  localparam sym_t MULT = gf_alpha_pow(STEP);

  sym_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= init_i;
    else if (adv_i)  val_q <= gf_mul(val_q, MULT);
  end

  assign val_o = val_q;
endmodule

// File: rtl/rs_forney_div.sv
`timescale 1ns/1ps
module rs_forney_div
  import rs_chien_pkg::*;
(
  input  sym_t num_i,
  input  sym_t den_i,
  output sym_t mag_o
);
  assign mag_o = gf_mul(num_i, gf_inv(den_i));
endmodule

// File: rtl/rs_chien_forney.sv
`timescale 1ns/1ps
module rs_chien_forney
  import rs_chien_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      err_cnt_i,
  input  logic [GF_M-1:0] sigma0_i,
  input  logic [GF_M-1:0] sigma1_i,
  input  logic [GF_M-1:0] sigma2_i,
  input  logic [GF_M-1:0] omega0_i,
  input  logic [GF_M-1:0] omega1_i,
  input  logic [GF_M-1:0] omega2_i,
  input  logic            rx_vld_i,
  input  logic [GF_M-1:0] rx_sym_i,
  output logic            sym_vld_o,
  output logic [GF_M-1:0] sym_o,
  output logic            corr_o,
  output logic            done_o,
  output logic            fail_o
);
  localparam int unsigned POS_W = $clog2(GF_N);
  localparam int unsigned CNT_W = $clog2(GF_N + 1);
  localparam int unsigned NT    = 6;
  // term order: loc x, loc x^2, loc x^3, omega x, omega x^2, derivative x^2
  localparam int unsigned TERM_STEP [NT] = '{1, 2, 3, 1, 2, 2};

  tmode_e mode_d, mode_q;
  sym_t c0_d, c1_d, c2_d, c3_d, w0_d, w1_d, w2_d;
  sym_t c0_q, c1_q, w0_q;
  sym_t term_init [NT];
  sym_t term_val  [NT];
  logic active_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] roots_q;
  logic accept, last, is_root;
  logic [CNT_W-1:0] roots_nxt;
  sym_t loc_sum, num, den, mag;

  // coefficient forcing per error count
  always_comb begin
    mode_d = tmode_e'(err_cnt_i);
    c0_d = sigma0_i; c1_d = sigma1_i; c2_d = sigma2_i; c3_d = sym_t'(1);
    w0_d = omega0_i; w1_d = omega1_i; w2_d = omega2_i;
    unique case (mode_d)
      T_NONE: begin
        c0_d = sym_t'(1); c1_d = '0; c2_d = '0; c3_d = '0;
        w0_d = '0; w1_d = '0; w2_d = '0;
      end
      T_ONE: begin
        c1_d = sym_t'(1); c2_d = '0; c3_d = '0; w1_d = '0; w2_d = '0;
      end
      T_TWO: begin
        c2_d = sym_t'(1); c3_d = '0; w2_d = '0;
      end
      T_THREE: ;
    endcase
  end

  assign term_init[0] = c1_d;
  assign term_init[1] = c2_d;
  assign term_init[2] = c3_d;
  assign term_init[3] = w1_d;
  assign term_init[4] = w2_d;
  assign term_init[5] = c3_d;

  assign accept = active_q & rx_vld_i;
  assign last   = pos_q == POS_W'(GF_N - 1);

  for (genvar g = 0; g < NT; g++) begin : g_term
    rs_step_term #(.STEP(TERM_STEP[g])) u_term (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_i),
      .init_i (term_init[g]),
      .adv_i  (accept),
      .val_o  (term_val[g])
    );
  end

  assign loc_sum   = c0_q ^ term_val[0] ^ term_val[1] ^ term_val[2];
  assign is_root   = (mode_q != T_NONE) && (loc_sum == '0);
  assign num       = w0_q ^ term_val[3] ^ term_val[4];
  assign den       = c1_q ^ term_val[5];
  assign roots_nxt = roots_q + CNT_W'(is_root);

  rs_forney_div u_div (
    .num_i (num),
    .den_i (den),
    .mag_o (mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      roots_q  <= '0;
      mode_q   <= T_NONE;
      c0_q     <= '0;
      c1_q     <= '0;
      w0_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      pos_q    <= '0;
      roots_q  <= '0;
      mode_q   <= mode_d;
      c0_q     <= c0_d;
      c1_q     <= c1_d;
      w0_q     <= w0_d;
    end else if (accept) begin
      pos_q   <= pos_q + 1'b1;
      roots_q <= roots_nxt;
      if (last) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_vld_o <= 1'b0;
      sym_o     <= '0;
      corr_o    <= 1'b0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      sym_vld_o <= accept;
      corr_o    <= accept & is_root;
      done_o    <= accept & last;
      fail_o    <= accept & last & (roots_nxt != CNT_W'(mode_q));
      if (accept) sym_o <= rx_sym_i ^ (is_root ? mag : '0);
    end
  end

  AST_PASS_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o && !corr_o |-> sym_o == $past(rx_sym_i));  // R7
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !start_i |=> !sym_vld_o);  // R9
  AST_FAIL_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && sym_vld_o);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_ROOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roots_q <= CNT_W'(3));  // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !rx_vld_i && !start_i |=> $stable(pos_q) && !sym_vld_o);  // R10
endmodule

// File: tb/rs_chien_forney_tb.sv
`timescale 1ns/1ps
module rs_chien_forney_tb;
  import rs_chien_pkg::*;
  localparam int M    = GF_M;
  localparam int N    = (1 << M) - 1;
  localparam int POLY = int'(GF_POLY);
  localparam int NPAR = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] err_cnt_i = '0;
  logic [M-1:0] sigma0_i = '0, sigma1_i = '0, sigma2_i = '0;
  logic [M-1:0] omega0_i = '0, omega1_i = '0, omega2_i = '0;
  logic rx_vld_i = 1'b0;
  logic [M-1:0] rx_sym_i = '0;
  logic sym_vld_o, corr_o, done_o, fail_o;
  logic [M-1:0] sym_o;

  always #2 clk_i = ~clk_i;

  rs_chien_forney u_dut (
    .clk_i, .rst_ni, .start_i, .err_cnt_i,
    .sigma0_i, .sigma1_i, .sigma2_i, .omega0_i, .omega1_i, .omega2_i,
    .rx_vld_i, .rx_sym_i, .sym_vld_o, .sym_o, .corr_o, .done_o, .fail_o
  );

  typedef struct {int cyc; int sym; bit corr; bit done; bit fail; string req;} exp_t;
  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit mon_en = 0, ev;
  int apow[N];

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = M - 1; i >= 0; i--) begin
      p = p << 1;
      if ((p >> M) & 1) p = p ^ POLY;
      if ((b >> i) & 1) p = p ^ a;
    end
    return p;
  endfunction

  function automatic int ginv(int a);
    for (int b = 1; b <= N; b++) if (gmul(a, b) == 1) return b;
    return 0;
  endfunction

  function automatic int peval(int c[4], int x);
    int r = 0;
    for (int k = 3; k >= 0; k--) r = gmul(r, x) ^ c[k];
    return r;
  endfunction

  function automatic int rnd_sym();
    return int'($urandom % (N + 1));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc_cnt);
    end
  endtask

  always @(posedge clk_i) cyc_cnt <= cyc_cnt + 1;

  // per-cycle comparison against the queued model
  always @(negedge clk_i) if (mon_en) begin
    ev = q.size() > 0 && q[0].cyc == cyc_cnt - 1;
    if (!ev) begin
      check({sym_vld_o, done_o, fail_o} == 3'b000, "R9/R2", "no output expected",
            {sym_vld_o, done_o, fail_o}, 0);
    end else begin
      e = q.pop_front();
      check(sym_vld_o == 1'b1, e.req, "R2 valid", sym_vld_o, 1);
      check(sym_o == e.sym[M-1:0], e.req, "symbol", sym_o, e.sym);
      check(corr_o == e.corr, {e.req, "/R7"}, "corr", corr_o, e.corr);
      check({done_o, fail_o} == {e.done, e.fail}, {e.req, "/R8"}, "done,fail",
            {done_o, fail_o}, {e.done, e.fail});
    end
  end

  // mode, error weight, locator-without-roots case, edge positions, stall percent
  task automatic run_block(int mode, int wgt, bit nofind, bit edge_pos, int gap_pct);
    int g[NPAR+1];
    int msg[N];
    int cw[N];
    int rx[N];
    int emask[N];
    int epos[3];
    int s[4];
    int w[4];
    int nt[4];
    string tag;
    g[0] = 1;
    for (int k = 1; k <= NPAR; k++) g[k] = 0;
    for (int i = 1; i <= NPAR; i++)
      for (int k = NPAR; k >= 0; k--)
        g[k] = gmul(g[k], apow[i]) ^ ((k > 0) ? g[k-1] : 0);
    for (int k = 0; k < N; k++) begin cw[k] = 0; emask[k] = 0; end
    for (int k = 0; k < N - NPAR; k++) msg[k] = rnd_sym();
    for (int a = 0; a < N - NPAR; a++)
      for (int b = 0; b <= NPAR; b++) cw[a+b] = cw[a+b] ^ gmul(msg[a], g[b]);
    for (int k = 0; k < N; k++) rx[k] = cw[k];
    for (int j = 0; j < wgt; j++) begin
      int p;
      if (edge_pos && j == 0) p = 0;
      else if (edge_pos && j == 1) p = N - 1;
      else begin
        p = int'($urandom % N);
        while (emask[p] != 0) p = int'($urandom % N);
      end
      epos[j] = p;
      emask[p] = 1 + int'($urandom % N);
      rx[p] = rx[p] ^ emask[p];
    end
    s = '{1, 0, 0, 0};
    for (int j = 0; j < wgt; j++)
      for (int k = 3; k >= 0; k--)
        s[k] = gmul(s[k], apow[epos[j]]) ^ ((k > 0) ? s[k-1] : 0);
    w = '{0, 0, 0, 0};
    for (int j = 0; j < wgt; j++) begin
      nt = '{emask[epos[j]], 0, 0, 0};
      for (int i = 0; i < wgt; i++) if (i != j)
        for (int k = 3; k >= 0; k--)
          nt[k] = gmul(nt[k], apow[epos[i]]) ^ ((k > 0) ? nt[k-1] : 0);
      for (int k = 0; k < 4; k++) w[k] = w[k] ^ nt[k];
    end
    if (nofind) begin
      // x^2 + x + c with no root in the field
      for (int c = 1; c <= N; c++) begin
        bit hit = 0;
        s = '{c, 1, 1, 0};
        for (int x = 0; x <= N; x++) if (peval(s, x) == 0) hit = 1;
        if (!hit) break;
      end
      w = '{rnd_sym(), rnd_sym(), 0, 0};
    end
    case (mode)
      3: tag = "R3";
      2: tag = "R4";
      1: tag = "R5";
      default: tag = "R6";
    endcase
    if (nofind) tag = "R8";
    @(negedge clk_i);
    start_i   = 1'b1;
    err_cnt_i = 2'(mode);
    sigma0_i  = M'((mode >= 1) ? s[0] : rnd_sym());
    sigma1_i  = M'((mode >= 2) ? s[1] : rnd_sym());
    sigma2_i  = M'((mode >= 3) ? s[2] : rnd_sym());
    omega0_i  = M'((mode >= 1) ? w[0] : rnd_sym());
    omega1_i  = M'((mode >= 2) ? w[1] : rnd_sym());
    omega2_i  = M'((mode >= 3) ? w[2] : rnd_sym());
    rx_vld_i  = 1'b0;
    for (int l = 0; l < N; l++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      while (int'($urandom % 100) < gap_pct) begin  // R10 stall
        rx_vld_i = 1'b0;
        rx_sym_i = M'(rnd_sym());
        @(negedge clk_i);
      end
      rx_vld_i = 1'b1;
      rx_sym_i = M'(rx[l]);
      e.cyc  = cyc_cnt;
      e.sym  = nofind ? rx[l] : cw[l];
      e.corr = !nofind && emask[l] != 0;
      e.done = (l == N - 1);
      e.fail = (l == N - 1) && nofind;
      e.req  = tag;
      q.push_back(e);
    end
    @(negedge clk_i);
    rx_vld_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++) begin  // R9
      @(negedge clk_i);
      rx_vld_i = 1'b1;
      rx_sym_i = M'(rnd_sym());
    end
    @(negedge clk_i);
    rx_vld_i = 1'b0;
  endtask

  initial begin
    apow[0] = 1;
    for (int i = 1; i < N; i++) begin
      apow[i] = apow[i-1] << 1;
      if ((apow[i] >> M) & 1) apow[i] = apow[i] ^ POLY;
    end
    repeat (3) @(negedge clk_i);
    check({sym_vld_o, corr_o, done_o, fail_o} == 4'b0000, "R1", "in reset",
          {sym_vld_o, corr_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({sym_vld_o, corr_o, done_o, fail_o} == 4'b0000, "R1", "after reset",
          {sym_vld_o, corr_o, done_o, fail_o}, 0);
    mon_en = 1;
    idle_noise(4);
    for (int rep = 0; rep < 6; rep++)
      for (int t = 0; t < 4; t++)
        run_block(t, t, 1'b0, 1'b0, (rep % 2) ? 30 : 0);
    run_block(3, 3, 1'b0, 1'b1, 0);
    run_block(2, 2, 1'b0, 1'b1, 20);
    run_block(1, 1, 1'b0, 1'b1, 0);
    run_block(2, 0, 1'b1, 1'b0, 0);
    run_block(2, 0, 1'b1, 1'b0, 25);
    idle_noise(5);
    repeat (3) @(negedge clk_i);
    check(q.size() == 0, "R2", "pending results", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule